// File: doc/BRIEF.md
# Synchronous I/O Cycle Tracker

On a field bus where a master polls its slaves in rising address order, this block lets many slaves apply new output data at the same moment and capture their inputs together. It watches every valid data-exchange telegram on the bus and works out which address is the lowest in the network. It then treats each exchange with that address as the shared synchronization instant.

The lowest address is learned from the polling order. Whenever a telegram carries an address below the one before it, a new polling cycle has begun, and that lower address is taken as the network minimum. Output data from the slave's own exchange waits in a holding register until the next synchronization instant. At that instant it moves to the output register, and an input-sample strobe fires in the same cycle. A run of repeated telegrams to one address suspends synchronization until a different address is polled. When the mode is switched off, the block passes its own exchange data straight through.

Top module: `sio_sync_tracker`

## Requirements
- R1: After reset, `dout` is 0, `in_sample` is 0 and `locked` is 0.
- R2: While `sync_en` is 0, an `own_xchg` strobe puts `own_data` on `dout` in the next cycle and pulses `in_sample` in that same cycle; `locked` stays 0 even when addresses descend.
- R3: While `sync_en` is 1 and no address descent has been seen since enable, `in_sample` stays 0, `locked` stays 0, and `dout` keeps its value through own exchanges.
- R4: With `sync_en` at 1, a telegram whose address is lower than that of the previous valid telegram sets `locked` in the next cycle. That telegram is itself a synchronization instant.
- R5: When enabled, `own_data` is stored in a holding register. `dout` takes the held value only at a synchronization instant: one cycle after a telegram to the learned lowest address, in the same cycle as the `in_sample` pulse.
- R6: When locked, telegrams to addresses other than the lowest produce no `in_sample` pulse and leave `dout` unchanged.
- R7: The first three consecutive telegrams to the lowest address each count as synchronization instants. The fourth and every later one in the same run do not. A telegram to any different address ends the run.
- R8: When `own_xchg` arrives in the same cycle as a synchronization telegram, the new `own_data` goes to `dout` directly.
- R9: A later descent to a different address replaces the learned lowest address, and synchronization follows the new address.
- R10: Clearing `sync_en` clears `locked` in the next cycle. After re-enable, the block is unlocked until a fresh descent is seen, and the first telegram after re-enable cannot cause one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_en | input | 1 | Synchronous mode enable |
| tlg_valid | input | 1 | One-cycle strobe for a valid data-exchange telegram on the bus |
| tlg_addr | input | ADDR_W (5) | Slave address of that telegram |
| own_xchg | input | 1 | One-cycle strobe for this slave's own data exchange |
| own_data | input | DATA_W (4) | Output data received in the own exchange |
| dout | output | DATA_W (4) | Synchronized output register |
| in_sample | output | 1 | Input-sample strobe, one cycle per synchronization instant |
| locked | output | 1 | A lowest address has been learned |

## Verification
The bench goes after the cycle in which the lowest address is first learned. A design that waited for a second visit to that address would miss the strobe on the descent telegram itself. It probes the fourth repeated telegram, where an off-by-one run counter either suppresses one telegram too early or lets the fourth one through. It drives an own exchange that coincides with a synchronization telegram; a design without forwarding would latch the stale held value. It also clears and re-enables the mode, where leftover address history would let the first telegram after re-enable look like a descent and lock too early.

// File: rtl/sio_sync_pkg.sv
package sio_sync_pkg;

   // Saturating increment for small run counters.
   function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
      return (v >= lim) ? lim : v + 1;
   endfunction

   // Address comparison outcome for one telegram against the previous one.
   typedef enum logic [1:0] {
      CMP_NONE    = 2'd0,
      CMP_SAME    = 2'd1,
      CMP_DESCENT = 2'd2,
      CMP_ASCENT  = 2'd3
   } addr_cmp_e;

endpackage

// File: rtl/sio_order_tracker.sv
module sio_order_tracker
   import sio_sync_pkg::*;
#(
   parameter int ADDR_W       = 5,
   parameter int REPEAT_LIMIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tlg_valid,
   input  logic [ADDR_W-1:0] tlg_addr,
   output logic              sync_o,
   output logic              locked_o
);

   localparam int RUN_W = (REPEAT_LIMIT < 1) ? 1 : $clog2(REPEAT_LIMIT + 1);

   logic              prev_vld_q;
   logic [ADDR_W-1:0] prev_addr_q;
   logic              low_vld_q;
   logic [ADDR_W-1:0] low_addr_q;
   addr_cmp_e         cmp;
   logic              rep_hit;
   logic              lock_nxt;
   logic [ADDR_W-1:0] low_nxt;

   always_comb begin
      if (!prev_vld_q)                cmp = CMP_NONE;
      else if (tlg_addr == prev_addr_q) cmp = CMP_SAME;
      else if (tlg_addr < prev_addr_q)  cmp = CMP_DESCENT;
      else                              cmp = CMP_ASCENT;
   end

   // Run-length handling of repeated telegrams; a zero limit removes it.
   generate
      if (REPEAT_LIMIT > 0) begin : g_run
         logic [RUN_W-1:0] run_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !en) begin
               run_q <= '0;
            end else if (tlg_valid) begin
               if (cmp == CMP_SAME)
                  run_q <= RUN_W'(sat_inc(int'(run_q), REPEAT_LIMIT));
               else
                  run_q <= RUN_W'(1);
            end
         end
         assign rep_hit = (cmp == CMP_SAME) && (run_q >= RUN_W'(REPEAT_LIMIT));
      end else begin : g_norun
         assign rep_hit = 1'b0;
      end
   endgenerate

   assign lock_nxt = low_vld_q | (cmp == CMP_DESCENT);
   assign low_nxt  = (cmp == CMP_DESCENT) ? tlg_addr : low_addr_q;
   assign sync_o   = en && tlg_valid && lock_nxt && (tlg_addr == low_nxt) && !rep_hit;
   assign locked_o = low_vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         prev_vld_q  <= 1'b0;
         prev_addr_q <= '0;
         low_vld_q   <= 1'b0;
         low_addr_q  <= '0;
      end else if (tlg_valid) begin
         prev_vld_q  <= 1'b1;
         prev_addr_q <= tlg_addr;
         low_vld_q   <= lock_nxt;
         low_addr_q  <= low_nxt;
      end
   end

endmodule

// File: rtl/sio_data_stage.sv
module sio_data_stage #(
   parameter int                DATA_W            = 4,
   parameter bit                SAME_CYCLE_BYPASS = 1'b1,
   parameter logic [DATA_W-1:0] RESET_DOUT        = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              sync_i,
   input  logic              own_xchg,
   input  logic [DATA_W-1:0] own_data,
   output logic [DATA_W-1:0] dout,
   output logic              in_sample
);

   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] sync_src;

   // Variant choice for an own exchange that lands on a sync telegram.
   generate
      if (SAME_CYCLE_BYPASS) begin : g_bypass
         assign sync_src = own_xchg ? own_data : hold_q;
      end else begin : g_nobypass
         assign sync_src = hold_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q    <= RESET_DOUT;
         dout      <= RESET_DOUT;
         in_sample <= 1'b0;
      end else begin
         if (own_xchg) hold_q <= own_data;
         if (en) begin
            if (sync_i) dout <= sync_src;
            in_sample <= sync_i;
         end else begin
            if (own_xchg) dout <= own_data;
            in_sample <= own_xchg;
         end
      end
   end

endmodule

// File: rtl/sio_sync_tracker.sv
module sio_sync_tracker #(
   parameter int                ADDR_W            = 5,
   parameter int                DATA_W            = 4,
   parameter int                REPEAT_LIMIT      = 3,
   parameter bit                SAME_CYCLE_BYPASS = 1'b1,
   parameter logic [DATA_W-1:0] RESET_DOUT        = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_en,
   input  logic              tlg_valid,
   input  logic [ADDR_W-1:0] tlg_addr,
   input  logic              own_xchg,
   input  logic [DATA_W-1:0] own_data,
   output logic [DATA_W-1:0] dout,
   output logic              in_sample,
   output logic              locked
);

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 16) else $error("ADDR_W out of range");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
      assert (REPEAT_LIMIT >= 0 && REPEAT_LIMIT <= 255) else $error("REPEAT_LIMIT out of range");
   end

   logic sync_w;

   sio_order_tracker #(
      .ADDR_W      (ADDR_W),
      .REPEAT_LIMIT(REPEAT_LIMIT)
   ) u_order (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (sync_en),
      .tlg_valid(tlg_valid),
      .tlg_addr (tlg_addr),
      .sync_o   (sync_w),
      .locked_o (locked)
   );

   sio_data_stage #(
      .DATA_W           (DATA_W),
      .SAME_CYCLE_BYPASS(SAME_CYCLE_BYPASS),
      .RESET_DOUT       (RESET_DOUT)
   ) u_data (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (sync_en),
      .sync_i   (sync_w),
      .own_xchg (own_xchg),
      .own_data (own_data),
      .dout     (dout),
      .in_sample(in_sample)
   );

endmodule

// File: rtl/sio_sync_tracker_chk.sv
module sio_sync_tracker_chk #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sync_en,
   input logic              tlg_valid,
   input logic [ADDR_W-1:0] tlg_addr,
   input logic              own_xchg,
   input logic [DATA_W-1:0] own_data,
   input logic [DATA_W-1:0] dout,
   input logic              in_sample,
   input logic              locked
);

   // Independent tally of consecutive telegrams to one address.
   logic              c_vld;
   logic [ADDR_W-1:0] c_addr;
   logic [2:0]        c_cnt;
   logic              c_fourth;

   always_ff @(posedge clk) begin
      if (!rst_n || !sync_en) begin
         c_vld  <= 1'b0;
         c_addr <= '0;
         c_cnt  <= '0;
      end else if (tlg_valid) begin
         c_vld  <= 1'b1;
         c_addr <= tlg_addr;
         if (c_vld && tlg_addr == c_addr)
            c_cnt <= (c_cnt == 3'd7) ? c_cnt : c_cnt + 3'd1;
         else
            c_cnt <= 3'd1;
      end
   end

   assign c_fourth = c_vld && (tlg_addr == c_addr) && (c_cnt >= 3'd3);

   assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_en && own_xchg |=> in_sample && dout == $past(own_data));

   assert_off_unlocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_en |=> !locked);

   assert_no_strobe_unlocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sync_en && !locked && !tlg_valid |=> !in_sample);

   assert_lock_is_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> in_sample);

   assert_dout_moves_on_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout) |-> in_sample);

   assert_repeat_suppressed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_en && tlg_valid && c_fourth |=> !in_sample);

endmodule

bind sio_sync_tracker sio_sync_tracker_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sync_en  (sync_en),
   .tlg_valid(tlg_valid),
   .tlg_addr (tlg_addr),
   .own_xchg (own_xchg),
   .own_data (own_data),
   .dout     (dout),
   .in_sample(in_sample),
   .locked   (locked)
);

// File: tb/sio_sync_tracker_tb_top.sv
`timescale 1ns/1ps
module sio_sync_tracker_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_en = 1'b0;
   logic       tlg_valid = 1'b0;
   logic [4:0] tlg_addr = '0;
   logic       own_xchg = 1'b0;
   logic [3:0] own_data = '0;
   logic [3:0] dout;
   logic       in_sample;
   logic       locked;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   sio_sync_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .sync_en(sync_en),
      .tlg_valid(tlg_valid), .tlg_addr(tlg_addr),
      .own_xchg(own_xchg), .own_data(own_data),
      .dout(dout), .in_sample(in_sample), .locked(locked)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One cycle of stimulus applied at a falling edge; outputs then reflect it.
   task automatic step(input bit tv, input int a, input bit ox, input int d);
      tlg_valid = tv; tlg_addr = 5'(a); own_xchg = ox; own_data = 4'(d);
      @(negedge clk);
      tlg_valid = 1'b0; own_xchg = 1'b0;
   endtask

   task automatic expect3(input string req, input int d, input int s, input int l);
      chk({req, " dout"}, int'(dout), d);
      chk({req, " in_sample"}, int'(in_sample), s);
      chk({req, " locked"}, int'(locked), l);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect3("R1 reset", 0, 0, 0);
   endtask

   task automatic t_disabled;
      sync_en = 1'b0;
      step(0, 0, 1, 4'hA);
      expect3("R2 passthrough", 4'hA, 1, 0);
      step(0, 0, 0, 0);
      chk("R2 strobe one cycle", int'(in_sample), 0);
      step(1, 10, 0, 0);
      step(1, 3, 0, 0);
      expect3("R2 descent ignored", 4'hA, 0, 0);
   endtask

   task automatic t_unlocked;
      sync_en = 1'b1;
      step(1, 5, 1, 4'h3);
      expect3("R3 own held", 4'hA, 0, 0);
      step(1, 6, 0, 0);
      step(1, 9, 0, 0);
      expect3("R3 ascending no lock", 4'hA, 0, 0);
   endtask

   task automatic t_lock;
      step(1, 2, 0, 0);
      expect3("R4 descent locks and syncs", 4'h3, 1, 1);
   endtask

   task automatic t_hold;
      step(1, 4, 1, 4'h7);
      expect3("R5 held until sync", 4'h3, 0, 1);
      step(1, 8, 0, 0);
      expect3("R6 other addr", 4'h3, 0, 1);
      step(1, 20, 0, 0);
      expect3("R6 other addr high", 4'h3, 0, 1);
      step(1, 2, 0, 0);
      expect3("R5 moved at sync", 4'h7, 1, 1);
   endtask

   task automatic t_repeat;
      step(1, 2, 0, 0);
      expect3("R7 second in run", 4'h7, 1, 1);
      step(1, 2, 0, 0);
      expect3("R7 third in run", 4'h7, 1, 1);
      step(0, 0, 1, 4'h5);
      chk("R7 own only no strobe", int'(in_sample), 0);
      step(1, 2, 0, 0);
      expect3("R7 fourth suppressed", 4'h7, 0, 1);
      step(1, 2, 0, 0);
      expect3("R7 fifth suppressed", 4'h7, 0, 1);
      step(1, 3, 0, 0);
      expect3("R7 run broken", 4'h7, 0, 1);
      step(1, 2, 0, 0);
      expect3("R7 sync resumes", 4'h5, 1, 1);
   endtask

   task automatic t_coincide;
      step(1, 2, 1, 4'hC);
      expect3("R8 forwarded", 4'hC, 1, 1);
   endtask

   task automatic t_relearn;
      step(1, 6, 0, 0);
      step(1, 12, 0, 0);
      step(0, 0, 1, 4'h9);
      step(1, 4, 0, 0);
      expect3("R9 new lowest", 4'h9, 1, 1);
      step(1, 5, 1, 4'h1);
      expect3("R9 non-lowest", 4'h9, 0, 1);
   endtask

   task automatic t_reenable;
      sync_en = 1'b0;
      step(0, 0, 0, 0);
      expect3("R10 disable unlocks", 4'h9, 0, 0);
      sync_en = 1'b1;
      step(1, 3, 0, 0);
      expect3("R10 first after enable", 4'h9, 0, 0);
      step(1, 1, 0, 0);
      expect3("R10 relock", 4'h1, 1, 1);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_disabled();
      t_unlocked();
      t_lock();
      t_hold();
      t_repeat();
      t_coincide();
      t_relearn();
      t_reenable();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule